// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor with Descending Round-Key Store

This block turns one 128-bit AES-128 ciphertext block back into plaintext, one inverse round per clock. The inverse cipher needs the round keys in reverse order, and the key schedule only runs forward. So each job has two phases. The first phase grows the full schedule from the cipher key into a store of eleven 128-bit round keys, one new key per cycle. The second phase walks that store from the last key down to the first while the state register passes through the inverse rounds.

A host presents a key and a ciphertext and pulses `start` while the core is idle. It then waits for the one-cycle `done` pulse and reads `plain_out`. The result stays on `plain_out` until the next job is accepted.

Bytes are numbered in the standard way. Bits 127:120 hold byte 0, and the block fills column by column, four bytes per column. Both the substitution tables are built when the design is elaborated, from GF(2^8) inversion under the polynomial 0x11B and the AES affine map. The forward table serves the key schedule and the inverse table serves the rounds.

Top module: `aes128_inv_core`

## Requirements
- R1: A synchronous active-low reset forces `busy` low, `done` low and `plain_out` to zero. A reset asserted during a job abandons that job.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is then high from the next cycle up to and including the cycle in which `done` is high, and low afterwards.
- R3: `done` is high for exactly one cycle. It comes 22 clock edges after the accepting edge (2·10 + 2).
- R4: With the byte order above, the core returns the standard plaintext for the published AES-128 known-answer vectors.
- R5: For any key and plaintext, encrypting with a reference cipher and then decrypting with the core gives back the original plaintext.
- R6: While `busy` is high, including the `done` cycle, `start` is ignored. `key` and `cipher_in` are sampled only at the accepting edge, so changing them later has no effect on the result or on the latency.
- R7: Outside a job, `plain_out` keeps its value until the next accepted `start`, whatever happens on `key` and `cipher_in`.
- R8: All ten derived round keys are in the store before the first key addition on the state. No inverse round runs before the expansion is complete.
- R9: The state is first XORed with round key 10. Nine rounds follow, each doing inverse row shift, inverse substitution, key addition and inverse column mixing with the coefficients {0E,0B,0D,09}. These use round keys 9 down to 1. A tenth round with round key 0 leaves out the column mixing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job; accepted only while idle |
| key | input | 128 | Cipher key, sampled at the accepting edge |
| cipher_in | input | 128 | Ciphertext block, sampled at the accepting edge |
| plain_out | output | 128 | Plaintext; valid while `done` is high and held afterwards |
| done | output | 1 | One-cycle pulse when `plain_out` holds the result |
| busy | output | 1 | High while a job is in progress |

## Verification
The bench builds the core with the package defaults: ten rounds, 128-bit key and block, and an eleven-entry key store. Under these defaults the published known-answer vectors apply directly, and so does a reference encryptor written separately inside the bench. This makes it possible to check the exact 22-cycle latency, to round-trip random blocks through the reference encryptor, and to test whether `start` and input changes are ignored during every phase, including the `done` cycle.

// File: rtl/aes_inv_pkg.sv
// Shared constants, types and GF(2^8) helpers for the AES-128 decryptor.
// Assumes: FIPS byte order (byte 0 in bits 127:120), reduction polynomial 0x11B.
// The forward and inverse substitution tables are computed at elaboration.
package aes_inv_pkg;

    localparam int AES_NR     = 10;                     // cipher rounds
    localparam int AES_BLK_W  = 128;                    // block and key width
    localparam int AES_WORD_W = 32;
    localparam int AES_NCOL   = 4;
    localparam int AES_NRK    = AES_NR + 1;             // round keys held
    localparam int RK_IDX_W   = $clog2(AES_NRK);
    localparam int AES_LAT    = 2 * AES_NR + 2;         // start edge to done
    localparam logic [7:0] GF_RED = 8'h1B;              // low byte of 0x11B

    typedef logic [7:0] byte_t;
    typedef byte_t sbox_tbl_t [256];

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_EXPAND,
        DS_ADDKEY,
        DS_ROUNDS,
        DS_DONE
    } dec_state_e;

    // Multiply by x in GF(2^8).
    function automatic byte_t gf_xtime(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? GF_RED : 8'h00);
    endfunction

    // General GF(2^8) multiply, shift-and-add.
    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc = 8'h00;
        byte_t p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_xtime(p);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 (maps 0 to 0).
    function automatic byte_t gf_inv(byte_t a);
        byte_t r = 8'h01;
        byte_t p = a;
        logic [7:0] e = 8'hFE;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    // Left rotation of a byte by n bits.
    function automatic byte_t rotl8(byte_t a, int n);
        logic [15:0] d;
        d = {a, a} << n;
        return d[15:8];
    endfunction

    // Forward and inverse affine maps.
    function automatic byte_t aff_fwd(byte_t x);
        return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ 8'h63;
    endfunction

    function automatic byte_t aff_inv(byte_t x);
        return rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05;
    endfunction

    // Build a 256-entry substitution table, inverse or forward.
    function automatic sbox_tbl_t build_tbl(bit inverse);
        sbox_tbl_t t;
        for (int i = 0; i < 256; i++) begin
            t[i] = inverse ? gf_inv(aff_inv(byte_t'(i))) : aff_fwd(gf_inv(byte_t'(i)));
        end
        return t;
    endfunction

    localparam sbox_tbl_t FWD_SBOX = build_tbl(1'b0);
    localparam sbox_tbl_t INV_SBOX = build_tbl(1'b1);

endpackage

// File: rtl/aes_key_bank.sv
// Round-key store: on load it captures the cipher key as entry 0, then each
// step derives the next forward key and writes it to the next entry.
// Assumes step is only raised after load and at most AES_NR times per job.
// bank_ready goes high once the last entry has been written.
module aes_key_bank
    import aes_inv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [AES_BLK_W-1:0]  key_in,
    input  logic [RK_IDX_W-1:0]   rd_idx,
    output logic [AES_BLK_W-1:0]  rd_key,
    output logic                  bank_ready
);

    logic [AES_BLK_W-1:0]  bank [AES_NRK];
    logic [AES_BLK_W-1:0]  tail;
    logic [AES_BLK_W-1:0]  next_key;
    logic [RK_IDX_W-1:0]   wr_idx;
    byte_t                 rcon;
    logic [AES_WORD_W-1:0] rot_w, sub_w, mix_w;
    logic [AES_WORD_W-1:0] nw [AES_NCOL];

    // Schedule core: rotate, substitute, add the round constant.
    always_comb begin
        rot_w = {tail[23:0], tail[31:24]};
        for (int b = 0; b < 4; b++) begin
            sub_w[8*b +: 8] = FWD_SBOX[rot_w[8*b +: 8]];
        end
        mix_w = sub_w ^ {rcon, 24'h000000};
    end

    // Chain the four words of the next round key.
    always_comb begin
        nw[0] = tail[AES_BLK_W-1 -: AES_WORD_W] ^ mix_w;
        for (int w = 1; w < AES_NCOL; w++) begin
            nw[w] = tail[AES_BLK_W-1-AES_WORD_W*w -: AES_WORD_W] ^ nw[w-1];
        end
        next_key = {nw[0], nw[1], nw[2], nw[3]};
    end

    // Schedule bookkeeping: latest key, round constant, write pointer, ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail       <= '0;
            rcon       <= 8'h01;
            wr_idx     <= '0;
            bank_ready <= 1'b0;
        end else if (load) begin
            tail       <= key_in;
            rcon       <= 8'h01;
            wr_idx     <= RK_IDX_W'(1);
            bank_ready <= 1'b0;
        end else if (step) begin
            tail       <= next_key;
            rcon       <= gf_xtime(rcon);
            wr_idx     <= wr_idx + RK_IDX_W'(1);
            bank_ready <= (wr_idx == RK_IDX_W'(AES_NR));
        end
    end

    // One register per store entry, written on its own pointer match.
    for (genvar g = 0; g < AES_NRK; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (load && (g == 0)) begin
                bank[g] <= key_in;
            end else if (step && (wr_idx == RK_IDX_W'(g))) begin
                bank[g] <= next_key;
            end
        end
    end

    assign rd_key = bank[rd_idx];

endmodule

// File: rtl/aes_inv_round.sv
// One combinational inverse round: inverse row shift, inverse substitution,
// key addition, then inverse column mixing unless last is high.
// Assumes FIPS byte order with column-major filling of the block.
module aes_inv_round
    import aes_inv_pkg::*;
(
    input  logic [AES_BLK_W-1:0] blk_in,
    input  logic [AES_BLK_W-1:0] rkey,
    input  logic                 last,
    output logic [AES_BLK_W-1:0] blk_out
);

    logic [AES_BLK_W-1:0] sub_q;
    logic [AES_BLK_W-1:0] ark_q;
    logic [AES_BLK_W-1:0] mix_q;

    // Inverse column-mix output byte: row r of {0E,0B,0D,09} rotated.
    function automatic byte_t imix_byte(byte_t a0, byte_t a1, byte_t a2, byte_t a3);
        return gf_mul(a0, 8'h0E) ^ gf_mul(a1, 8'h0B) ^ gf_mul(a2, 8'h0D) ^ gf_mul(a3, 8'h09);
    endfunction

    // Row r moves right by r columns, then each byte goes through the inverse table.
    for (genvar c = 0; c < AES_NCOL; c++) begin : g_col_sub
        for (genvar r = 0; r < 4; r++) begin : g_row_sub
            localparam int SRC = 4 * ((c - r + AES_NCOL) % AES_NCOL) + r;
            localparam int DST = 4 * c + r;
            assign sub_q[AES_BLK_W-1-8*DST -: 8] = INV_SBOX[blk_in[AES_BLK_W-1-8*SRC -: 8]];
        end
    end

    assign ark_q = sub_q ^ rkey;

    // Column mixing, one column of four bytes at a time.
    for (genvar c = 0; c < AES_NCOL; c++) begin : g_col_mix
        byte_t a [4];
        for (genvar r = 0; r < 4; r++) begin : g_ld
            assign a[r] = ark_q[AES_BLK_W-1-8*(4*c+r) -: 8];
        end
        for (genvar r = 0; r < 4; r++) begin : g_out
            assign mix_q[AES_BLK_W-1-8*(4*c+r) -: 8] =
                imix_byte(a[r], a[(r+1)%4], a[(r+2)%4], a[(r+3)%4]);
        end
    end

    assign blk_out = last ? ark_q : mix_q;

endmodule

// File: rtl/aes_inv_ctrl.sv
// Job sequencer: idle -> expand (until the key store reports ready) ->
// initial key addition with the top key -> rounds with descending key
// index -> done pulse -> idle. start is looked at only in idle.
module aes_inv_ctrl
    import aes_inv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                bank_ready,
    output logic                load_key,
    output logic                step_key,
    output logic                add_first,
    output logic                round_en,
    output logic                round_last,
    output logic [RK_IDX_W-1:0] rk_idx,
    output logic                busy,
    output logic                done
);

    dec_state_e          st_q;
    logic [RK_IDX_W-1:0] rnd_q;

    // State register and descending round counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DS_IDLE;
            rnd_q <= '0;
        end else begin
            case (st_q)
                DS_IDLE:   if (start) st_q <= DS_EXPAND;
                DS_EXPAND: if (bank_ready) st_q <= DS_ADDKEY;
                DS_ADDKEY: begin
                    rnd_q <= RK_IDX_W'(AES_NR - 1);
                    st_q  <= DS_ROUNDS;
                end
                DS_ROUNDS: begin
                    if (rnd_q == '0) st_q <= DS_DONE;
                    else             rnd_q <= rnd_q - RK_IDX_W'(1);
                end
                default:   st_q <= DS_IDLE;
            endcase
        end
    end

    // Decode of per-state strobes and the key-store read index.
    always_comb begin
        load_key   = (st_q == DS_IDLE) && start;
        step_key   = (st_q == DS_EXPAND) && !bank_ready;
        add_first  = (st_q == DS_ADDKEY);
        round_en   = (st_q == DS_ROUNDS);
        round_last = round_en && (rnd_q == '0);
        rk_idx     = add_first ? RK_IDX_W'(AES_NR) : rnd_q;
        busy       = (st_q != DS_IDLE);
        done       = (st_q == DS_DONE);
    end

endmodule

// File: rtl/aes128_inv_core.sv
// AES-128 block decryptor top: key store, sequencer, one inverse round
// and the 128-bit state register, which also drives plain_out.
// plain_out is meaningful while done is high and held until the next job.
module aes128_inv_core
    import aes_inv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AES_BLK_W-1:0] key,
    input  logic [AES_BLK_W-1:0] cipher_in,
    output logic [AES_BLK_W-1:0] plain_out,
    output logic                 done,
    output logic                 busy
);

    logic                 load_key, step_key, add_first, round_en, round_last;
    logic                 bank_ready;
    logic [RK_IDX_W-1:0]  rk_idx;
    logic [AES_BLK_W-1:0] rk;
    logic [AES_BLK_W-1:0] state_q;
    logic [AES_BLK_W-1:0] round_out;

    aes_inv_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .bank_ready (bank_ready),
        .load_key   (load_key),
        .step_key   (step_key),
        .add_first  (add_first),
        .round_en   (round_en),
        .round_last (round_last),
        .rk_idx     (rk_idx),
        .busy       (busy),
        .done       (done)
    );

    aes_key_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_key),
        .step       (step_key),
        .key_in     (key),
        .rd_idx     (rk_idx),
        .rd_key     (rk),
        .bank_ready (bank_ready)
    );

    aes_inv_round u_round (
        .blk_in  (state_q),
        .rkey    (rk),
        .last    (round_last),
        .blk_out (round_out)
    );

    // State register: capture ciphertext, add the top key, then step rounds.
    always_ff @(posedge clk) begin
        if (!rst_n)         state_q <= '0;
        else if (load_key)  state_q <= cipher_in;
        else if (add_first) state_q <= state_q ^ rk;
        else if (round_en)  state_q <= round_out;
    end

    assign plain_out = state_q;

endmodule

// File: rtl/aes_inv_chk.sv
// Protocol and ordering checks for aes128_inv_core, attached by bind.
// Looks at the top ports plus the sequencer/key-store handshake.
module aes_inv_chk
    import aes_inv_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [AES_BLK_W-1:0] plain_out,
    input logic                 round_en,
    input logic                 bank_ready,
    input logic [RK_IDX_W-1:0]  rk_idx
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !done && plain_out == '0)); // R1

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(plain_out)); // R7

    AST_EXPAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        round_en |-> bank_ready); // R8

    AST_FIRST_ROUND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(round_en) |-> (rk_idx == RK_IDX_W'(AES_NR - 1))); // R9

    AST_KEY_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (round_en && $past(round_en)) |-> (rk_idx == $past(rk_idx) - RK_IDX_W'(1))); // R9

endmodule

bind aes128_inv_core aes_inv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .plain_out  (plain_out),
    .round_en   (round_en),
    .bank_ready (bank_ready),
    .rk_idx     (rk_idx)
);

// File: tb/sim_aes128_inv_core.sv
// Bench for aes128_inv_core: known-answer table, random round trips against
// a reference encryptor written here, then directed protocol cases.
module sim_aes128_inv_core;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_LAT    = 22;
    localparam int WAIT_MAX   = 100;

    typedef struct packed {
        logic [127:0] key;
        logic [127:0] pt;
        logic [127:0] ct;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a},
        '{128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
          128'h3925841d02dc09fbdc118597196a0b32},
        '{128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000,
          128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] ct_i = '0;
    logic [127:0] plain_out;
    logic         done, busy;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] sb [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    aes128_inv_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .key       (key_i),
        .cipher_in (ct_i),
        .plain_out (plain_out),
        .done      (done),
        .busy      (busy)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference GF multiply, independent bit loop.
    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] gb(logic [127:0] s, int i);
        return s[127-8*i -: 8];
    endfunction

    // Reference AES-128 encryption.
    function automatic logic [127:0] m_encrypt(logic [127:0] k, logic [127:0] p);
        logic [31:0]  w [44];
        logic [31:0]  t;
        logic [7:0]   rc = 8'h01;
        logic [127:0] s, n;
        logic [7:0]   a0, a1, a2, a3;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
                rc = m_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        s = p ^ {w[0], w[1], w[2], w[3]};
        for (int rd = 1; rd <= 10; rd++) begin
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    n[127-8*(4*c+r) -: 8] = sb[gb(s, 4*((c+r)%4)+r)];
            s = n;
            if (rd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = gb(s, 4*c); a1 = gb(s, 4*c+1); a2 = gb(s, 4*c+2); a3 = gb(s, 4*c+3);
                    n[127-8*(4*c)   -: 8] = m_mul(a0, 2) ^ m_mul(a1, 3) ^ a2 ^ a3;
                    n[127-8*(4*c+1) -: 8] = a0 ^ m_mul(a1, 2) ^ m_mul(a2, 3) ^ a3;
                    n[127-8*(4*c+2) -: 8] = a0 ^ a1 ^ m_mul(a2, 2) ^ m_mul(a3, 3);
                    n[127-8*(4*c+3) -: 8] = m_mul(a0, 3) ^ a1 ^ a2 ^ m_mul(a3, 2);
                end
                s = n;
            end
            s ^= {w[4*rd], w[4*rd+1], w[4*rd+2], w[4*rd+3]};
        end
        return s;
    endfunction

    // Start a job at a falling edge and count edges until done is seen.
    task automatic run_dec(input logic [127:0] k, input logic [127:0] c,
                           output logic [127:0] p, output int lat);
        @(negedge clk);
        key_i = k; ct_i = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < WAIT_MAX) begin
            @(negedge clk);
            lat++;
        end
        p = plain_out;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] got, k, p, held;
        int lat;
        logic [7:0] inv, bt;

        for (int x = 0; x < 256; x++) begin
            inv = 8'h00;
            for (int y = 1; y < 256; y++) if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                bt[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
                        ^ (((8'h63) >> i) & 1'b1);
            sb[x] = bt;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 128'(busy), 128'(0));
        chk("R1 done in reset", 128'(done), 128'(0));
        chk("R1 plain_out in reset", plain_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 128'(busy), 128'(0));

        // R4 R9 R3 R8: known-answer table
        for (int v = 0; v < 3; v++) begin
            chk("R4 reference model", m_encrypt(VECS[v].key, VECS[v].pt), VECS[v].ct);
            run_dec(VECS[v].key, VECS[v].ct, got, lat);
            chk("R4 R9 known vector", got, VECS[v].pt);
            chk("R3 R8 latency", 128'(lat), 128'(EXP_LAT));
            chk("R2 busy with done", 128'(busy), 128'(1));
            @(negedge clk);
            chk("R3 done single cycle", 128'(done), 128'(0));
            chk("R2 busy low after done", 128'(busy), 128'(0));
        end

        // R5: random round trips
        for (int t = 0; t < 24; t++) begin
            k = rnd128(); p = rnd128();
            run_dec(k, m_encrypt(k, p), got, lat);
            chk("R5 round trip", got, p);
        end

        // R2: busy rises the cycle after acceptance
        @(negedge clk);
        key_i = VECS[1].key; ct_i = VECS[1].ct; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after accept", 128'(busy), 128'(1));
        lat = 0;
        while (!done && lat < WAIT_MAX) begin @(negedge clk); lat++; end
        chk("R2 result", plain_out, VECS[1].pt);

        // R6: start held and inputs scrambled during the job
        @(negedge clk);
        @(negedge clk);
        key_i = VECS[0].key; ct_i = VECS[0].ct; start = 1'b1;
        @(negedge clk);
        lat = 0;
        key_i = rnd128(); ct_i = rnd128();
        for (int i = 0; i < 15; i++) begin @(negedge clk); lat++; end
        start = 1'b0;
        while (!done && lat < WAIT_MAX) begin @(negedge clk); lat++; end
        chk("R6 result unaffected", plain_out, VECS[0].pt);
        chk("R6 latency unaffected", 128'(lat), 128'(EXP_LAT));

        // R6: start during the done cycle is ignored
        key_i = VECS[2].key; ct_i = VECS[2].ct; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 start in done ignored", 128'(busy), 128'(0));
        chk("R6 output kept", plain_out, VECS[0].pt);

        // R7: output holds in idle while inputs move
        held = plain_out;
        for (int i = 0; i < 6; i++) begin
            key_i = rnd128(); ct_i = rnd128();
            @(negedge clk);
        end
        chk("R7 plain_out held", plain_out, held);
        chk("R7 stays idle", 128'(busy), 128'(0));

        // R1: reset in the middle of a job
        key_i = VECS[1].key; ct_i = VECS[1].ct; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-job reset busy", 128'(busy), 128'(0));
        chk("R1 mid-job reset output", plain_out, '0);
        rst_n = 1'b1;
        run_dec(VECS[1].key, VECS[1].ct, got, lat);
        chk("R1 job after reset", got, VECS[1].pt);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule